// File: doc/BRIEF.md
# One-Bit IF Downconverting Decimator

This block sits right behind a satellite-navigation radio front end that delivers a one-bit intermediate-frequency sample stream. It collects the serial bits into words of eight samples and maps each bit to +1 or -1. It multiplies every sample by a coarse complex carrier from a phase accumulator with a programmable step. The mixed samples pass through a 16-tap symmetric low-pass FIR. The FIR is evaluated only on every eighth sample, so the block emits baseband I/Q at one eighth of the input rate.

Output samples are grouped into frames. A frame is 16368 input samples, or 2046 output samples, which is one millisecond at the nominal rates. The first sample of each frame is flagged, and every sample carries the frame number as a timestamp. Parallel downstream channels use that number to line up their work on the same block of data. A small word buffer absorbs back-pressure from the output valid/ready stream. If the buffer is ever full when a word completes, that word is dropped and a sticky flag is raised.

Top module: `onebit_if_decimator`

## Requirements
- R1: Directly after a synchronous reset, out_valid and overflow are 0, and they stay 0 while no bits are supplied.
- R2: Input sample n counts from 0 at reset and maps to s = +1 when its bit is 1 and s = -1 when it is 0. Its carrier phase is n·phase_inc modulo 2^32, and k is the top 3 bits of that phase. With cos table [2,1,-1,-2,-2,-1,1,2] and sin table [1,2,2,1,-1,-2,-2,-1] indexed by k, the mixed sample is I = s·cos[k] and Q = -s·sin[k].
- R3: Output m (from 0) equals the sum over k = 0..15 of h[k]·x[8m-8+k], with h[k] = min(k+1, 16-k) and x[n] = 0 for n < 0. It is given separately for I and Q on out_i and out_q as 10-bit two's complement numbers.
- R4: Exactly one output is produced per eight accepted input bits. A cycle with in_valid low supplies no sample, and a trailing partial group of fewer than eight bits yields no output.
- R5: out_sof is 1 exactly on outputs whose index m is a multiple of 2046, so each frame spans 16368 input samples.
- R6: out_tstamp equals floor(m / 2046). It is 0 in the first frame, constant within a frame, and one higher in each following frame.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_i, out_q, out_sof and out_tstamp hold their values. No word is lost while the buffered data fits in the 16-word buffer, the staging word and the output register.
- R8: A completed word that arrives while the 16-word buffer is full is discarded. overflow then becomes 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_bit | input | 1 | One-bit IF sample |
| in_valid | input | 1 | in_bit holds a sample this cycle |
| phase_inc | input | 32 | Carrier phase step per input sample |
| out_ready | input | 1 | Consumer accepts the current output |
| out_valid | output | 1 | Output sample present |
| out_i | output | 10 | In-phase baseband sample, signed |
| out_q | output | 10 | Quadrature baseband sample, signed |
| out_sof | output | 1 | First sample of a frame |
| out_tstamp | output | 32 | Frame number of the current sample |
| overflow | output | 1 | Sticky: an input word was discarded |

## Verification
A carrier phase register that has slipped corrupts I and Q on the very next output, because every output depends on all sixteen phases in its window. A stale previous-word history shows up the same way, on the next output. A frame counter that is off moves out_sof and the timestamp step away from a multiple of 2046. This shows at the next frame boundary at the latest, which means within 2046 transfers. A lost or duplicated word shifts every later output against the bit stream, and it also breaks the exact ratio of one output per eight bits seen once the pipeline has drained.

// File: rtl/obd_pkg.sv
package obd_pkg;

  // Coarse carrier sample, values in {-2,-1,1,2}
  typedef logic signed [2:0] mix_t;

  // Octant-centred cosine, 3-bit phase index
  function automatic mix_t carrier_cos(input logic [2:0] oct);
    case (oct)
      3'd0:    return mix_t'(2);
      3'd1:    return mix_t'(1);
      3'd2:    return mix_t'(-1);
      3'd3:    return mix_t'(-2);
      3'd4:    return mix_t'(-2);
      3'd5:    return mix_t'(-1);
      3'd6:    return mix_t'(1);
      default: return mix_t'(2);
    endcase
  endfunction

  // Octant-centred sine, 3-bit phase index
  function automatic mix_t carrier_sin(input logic [2:0] oct);
    case (oct)
      3'd0:    return mix_t'(1);
      3'd1:    return mix_t'(2);
      3'd2:    return mix_t'(2);
      3'd3:    return mix_t'(1);
      3'd4:    return mix_t'(-1);
      3'd5:    return mix_t'(-2);
      3'd6:    return mix_t'(-2);
      default: return mix_t'(-1);
    endcase
  endfunction

  // Triangular symmetric tap weight
  function automatic int unsigned tap_weight(input int unsigned k, input int unsigned ntaps);
    return (k + 1 < ntaps - k) ? k + 1 : ntaps - k;
  endfunction

endpackage

// File: rtl/obd_packer.sv
module obd_packer #(
  parameter int DEC = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_bit,
  input  logic           in_valid,
  output logic [DEC-1:0] word,
  output logic           word_stb
);
  localparam int CW = $clog2(DEC);

  logic [CW-1:0] cnt;

  // word is the shift register itself; it is complete in the cycle word_stb is high
  always_ff @(posedge clk) begin
    if (in_valid) word[cnt] <= in_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      word_stb <= 1'b0;
    end else begin
      word_stb <= 1'b0;
      if (in_valid) begin
        if (cnt == CW'(DEC - 1)) begin
          cnt      <= '0;
          word_stb <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/obd_word_fifo.sv
module obd_word_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         ovf
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;
  logic         full;

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);

  // Block-RAM style: write port and registered read port, no reset
  always_ff @(posedge clk) begin
    if (push && !full) mem[wp[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (pop) rdata <= mem[rp[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      ovf <= 1'b0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop)           rp <= rp + 1'b1;
      if (push && full)  ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/obd_frame_tag.sv
module obd_frame_tag #(
  parameter int FRAME_OUT = 2046,
  parameter int TS_W      = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  output logic            sof,
  output logic [TS_W-1:0] ts
);
  localparam int CW = $clog2(FRAME_OUT);

  logic [CW-1:0] cnt;

  assign sof = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ts  <= '0;
    end else if (adv) begin
      if (cnt == CW'(FRAME_OUT - 1)) begin
        cnt <= '0;
        ts  <= ts + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/obd_mix_fir.sv
module obd_mix_fir
  import obd_pkg::*;
#(
  parameter int DEC   = 8,
  parameter int PHW   = 32,
  parameter int OUT_W = 10,
  parameter int TS_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PHW-1:0]          phase_inc,
  input  logic                    fifo_empty,
  input  logic [DEC-1:0]          fifo_rdata,
  output logic                    fifo_pop,
  input  logic                    sof_in,
  input  logic [TS_W-1:0]         ts_in,
  output logic                    adv,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_i,
  output logic signed [OUT_W-1:0] out_q,
  output logic                    out_sof,
  output logic [TS_W-1:0]         out_tstamp
);
  localparam int NT = 2 * DEC;

  function automatic logic signed [OUT_W-1:0] widen(input mix_t v);
    return {{(OUT_W-3){v[2]}}, v};
  endfunction

  logic           w_valid;
  logic [PHW-1:0] phase;
  mix_t cur_i [DEC];
  mix_t cur_q [DEC];
  mix_t prv_i [DEC];
  mix_t prv_q [DEC];
  logic signed [OUT_W-1:0] acc_i, acc_q;

  assign adv      = w_valid && (!out_valid || out_ready);
  assign fifo_pop = !fifo_empty && (!w_valid || adv);

  // Per-sample carrier and mixing for the staged word
  for (genvar j = 0; j < DEC; j++) begin : g_mix
    mix_t c_j, s_j;
    assign c_j = carrier_cos(3'((phase + PHW'(j) * phase_inc) >> (PHW - 3)));
    assign s_j = carrier_sin(3'((phase + PHW'(j) * phase_inc) >> (PHW - 3)));
    assign cur_i[j] = fifo_rdata[j] ? c_j : -c_j;
    assign cur_q[j] = fifo_rdata[j] ? -s_j : s_j;
  end

  // Folded symmetric FIR over previous and current word
  always_comb begin
    acc_i = '0;
    acc_q = '0;
    for (int k = 0; k < DEC; k++) begin
      logic signed [OUT_W-1:0] pre_i, pre_q, wt;
      pre_i = widen(prv_i[k]) + widen(cur_i[DEC-1-k]);
      pre_q = widen(prv_q[k]) + widen(cur_q[DEC-1-k]);
      wt    = $signed(OUT_W'(tap_weight(k, NT)));
      acc_i = acc_i + pre_i * wt;
      acc_q = acc_q + pre_q * wt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      w_valid    <= 1'b0;
      out_valid  <= 1'b0;
      phase      <= '0;
      out_i      <= '0;
      out_q      <= '0;
      out_sof    <= 1'b0;
      out_tstamp <= '0;
      for (int k = 0; k < DEC; k++) begin
        prv_i[k] <= '0;
        prv_q[k] <= '0;
      end
    end else begin
      if (fifo_pop)      w_valid <= 1'b1;
      else if (adv)      w_valid <= 1'b0;
      if (adv) begin
        out_valid  <= 1'b1;
        out_i      <= acc_i;
        out_q      <= acc_q;
        out_sof    <= sof_in;
        out_tstamp <= ts_in;
        phase      <= phase + PHW'(DEC) * phase_inc;
        prv_i      <= cur_i;
        prv_q      <= cur_q;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/onebit_if_decimator.sv
module onebit_if_decimator #(
  parameter int DEC        = 8,
  parameter int FRAME_IN   = 16368,
  parameter int PHW        = 32,
  parameter int OUT_W      = 10,
  parameter int TS_W       = 32,
  parameter int FIFO_DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_bit,
  input  logic             in_valid,
  input  logic [PHW-1:0]   phase_inc,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_i,
  output logic [OUT_W-1:0] out_q,
  output logic             out_sof,
  output logic [TS_W-1:0]  out_tstamp,
  output logic             overflow
);
  localparam int FRAME_OUT = FRAME_IN / DEC;

  logic [DEC-1:0]  pk_word, f_rdata;
  logic            pk_stb, f_empty, f_pop, adv, sof_n;
  logic [TS_W-1:0] ts_n;

  obd_packer #(.DEC(DEC)) packer_i (
    .clk(clk), .rst(rst), .in_bit(in_bit), .in_valid(in_valid),
    .word(pk_word), .word_stb(pk_stb)
  );

  obd_word_fifo #(.W(DEC), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .push(pk_stb), .wdata(pk_word), .pop(f_pop),
    .rdata(f_rdata), .empty(f_empty), .ovf(overflow)
  );

  obd_frame_tag #(.FRAME_OUT(FRAME_OUT), .TS_W(TS_W)) frame_i (
    .clk(clk), .rst(rst), .adv(adv), .sof(sof_n), .ts(ts_n)
  );

  obd_mix_fir #(.DEC(DEC), .PHW(PHW), .OUT_W(OUT_W), .TS_W(TS_W)) dp_i (
    .clk(clk), .rst(rst), .phase_inc(phase_inc),
    .fifo_empty(f_empty), .fifo_rdata(f_rdata), .fifo_pop(f_pop),
    .sof_in(sof_n), .ts_in(ts_n), .adv(adv),
    .out_ready(out_ready), .out_valid(out_valid),
    .out_i(out_i), .out_q(out_q), .out_sof(out_sof), .out_tstamp(out_tstamp)
  );
endmodule

// File: rtl/onebit_if_decimator_chk.sv
module onebit_if_decimator_chk #(
  parameter int DEC       = 8,
  parameter int FRAME_OUT = 2046,
  parameter int OUT_W     = 10,
  parameter int TS_W      = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             out_ready,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_i,
  input logic [OUT_W-1:0] out_q,
  input logic             out_sof,
  input logic [TS_W-1:0]  out_tstamp,
  input logic             overflow
);
  localparam int MAXMAG = 2 * DEC * (DEC + 1);
  localparam int IW     = $clog2(FRAME_OUT);

  logic            seen;
  logic [TS_W-1:0] last_ts;
  logic [IW-1:0]   idx;
  logic            xfer;

  assign xfer = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen    <= 1'b0;
      last_ts <= '0;
      idx     <= '0;
    end else if (xfer) begin
      seen    <= 1'b1;
      last_ts <= out_tstamp;
      idx     <= (idx == IW'(FRAME_OUT - 1)) ? '0 : idx + 1'b1;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_i) && $stable(out_q) && $stable(out_sof) && $stable(out_tstamp)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R8
  AST_SOF_POSITION: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sof == (idx == '0))); // R5
  AST_TS_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    out_valid && seen && !out_sof |-> out_tstamp == last_ts); // R6
  AST_TS_STEP: assert property (@(posedge clk) disable iff (rst)
    out_valid && seen && out_sof |-> out_tstamp == last_ts + TS_W'(1)); // R6
  AST_TS_FIRST: assert property (@(posedge clk) disable iff (rst)
    out_valid && !seen |-> out_tstamp == '0 && out_sof); // R6
  AST_MAG_BOUND: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> int'($signed(out_i)) <= MAXMAG && int'($signed(out_i)) >= -MAXMAG
               && int'($signed(out_q)) <= MAXMAG && int'($signed(out_q)) >= -MAXMAG); // R3
endmodule

bind onebit_if_decimator onebit_if_decimator_chk #(
  .DEC(DEC), .FRAME_OUT(FRAME_IN / DEC), .OUT_W(OUT_W), .TS_W(TS_W)
) chk_i (
  .clk(clk), .rst(rst), .out_ready(out_ready), .out_valid(out_valid),
  .out_i(out_i), .out_q(out_q), .out_sof(out_sof), .out_tstamp(out_tstamp),
  .overflow(overflow)
);

// File: tb/onebit_if_decimator_tb_top.sv
`timescale 1ns/1ps
module onebit_if_decimator_tb_top;
  localparam int DEC = 8, FRAME_IN = 16368, FRAME_OUT = FRAME_IN / DEC;
  localparam int OUT_W = 10, TS_W = 32, DEPTH = 16, NT = 2 * DEC;

  logic clk = 1'b0, rst = 1'b1, in_bit = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [31:0] phase_inc = '0;
  logic out_valid, out_sof, overflow;
  logic [OUT_W-1:0] out_i, out_q;
  logic [TS_W-1:0] out_tstamp;

  always #2.5 clk = ~clk;

  onebit_if_decimator dut_i (
    .clk(clk), .rst(rst), .in_bit(in_bit), .in_valid(in_valid), .phase_inc(phase_inc),
    .out_ready(out_ready), .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
    .out_sof(out_sof), .out_tstamp(out_tstamp), .overflow(overflow)
  );

  // Scenario table: carrier step, bit seed, ready pattern, valid pattern, outputs to collect
  localparam int NSC = 4;
  localparam logic [31:0] SC_INC  [NSC] = '{32'h4000_0000, 32'h1234_5679, 32'h0000_0000, 32'hFEDC_BA98};
  localparam logic [15:0] SC_SEED [NSC] = '{16'hACE1, 16'h1D2B, 16'h7FFF, 16'h0001};
  localparam logic [7:0]  SC_RDY  [NSC] = '{8'hFF, 8'b1010_0110, 8'hFF, 8'b0001_0001};
  localparam logic [7:0]  SC_VLD  [NSC] = '{8'hFF, 8'hFF, 8'b1101_1011, 8'b0111_1110};
  localparam int          SC_NOUT [NSC] = '{4200, 2100, 2100, 300};

  int n_chk = 0, n_fail = 0, rx = 0, cyc = 0;
  bit bits_q[$];
  logic [15:0] lfsr;
  logic [OUT_W-1:0] held_i;

  function automatic int cos_t(int k);
    int t[8] = '{2, 1, -1, -2, -2, -1, 1, 2};
    return t[k];
  endfunction
  function automatic int sin_t(int k);
    int t[8] = '{1, 2, 2, 1, -1, -2, -2, -1};
    return t[k];
  endfunction
  function automatic int wgt(int k);
    return (k + 1 < NT - k) ? k + 1 : NT - k;
  endfunction
  function automatic int mixed(int n, logic [31:0] inc, bit q);
    logic [63:0] p;
    int k, s;
    if (n < 0) return 0;
    p = 64'(n) * 64'(inc);
    k = int'(p[31:29]);
    s = bits_q[n] ? 1 : -1;
    return q ? -s * sin_t(k) : s * cos_t(k);
  endfunction
  function automatic int expect_out(int m, logic [31:0] inc, bit q);
    int acc = 0;
    for (int k = 0; k < NT; k++) acc += wgt(k) * mixed(DEC * m - DEC + k, inc, q);
    return acc;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_output(logic [31:0] inc);
    int ei, eq, ai, aq;
    ei = expect_out(rx, inc, 1'b0);
    eq = expect_out(rx, inc, 1'b1);
    ai = int'($signed(out_i));
    aq = int'($signed(out_q));
    check(ai == ei, "R2/R3", "I sample", ai, ei);
    check(aq == eq, "R2/R3", "Q sample", aq, eq);
    check(out_sof == ((rx % FRAME_OUT) == 0), "R5", "sof flag", out_sof, (rx % FRAME_OUT) == 0);
    check(out_tstamp == 32'(rx / FRAME_OUT), "R6", "timestamp", out_tstamp, rx / FRAME_OUT);
  endtask

  // One cycle: decide ready, check the transfer happening at the next edge, drive a bit
  task automatic step(bit rdy, bit vld, logic [31:0] inc, bit drive);
    @(negedge clk);
    out_ready = rdy;
    if (out_valid && rdy) begin
      check_output(inc);
      rx++;
    end
    if (drive && vld) begin
      in_bit   = lfsr[0];
      in_valid = 1'b1;
      bits_q.push_back(lfsr[0]);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end else begin
      in_valid = 1'b0;
    end
    cyc++;
  endtask

  task automatic do_reset(logic [31:0] inc, logic [15:0] seed);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; phase_inc = inc;
    lfsr = seed; bits_q.delete(); rx = 0; cyc = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(overflow == 1'b0, "R1", "overflow after reset", overflow, 0);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid idle", out_valid, 0);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    for (int s = 0; s < NSC; s++) begin
      do_reset(SC_INC[s], SC_SEED[s]);
      while (rx < SC_NOUT[s]) step(SC_RDY[s][cyc % 8], SC_VLD[s][cyc % 8], SC_INC[s], 1'b1);
      repeat (60) step(1'b1, 1'b0, SC_INC[s], 1'b0);
      // R4: one output per eight accepted bits, partial group dropped
      check(rx == bits_q.size() / DEC, "R4", "output count", rx, bits_q.size() / DEC);
      check(overflow == 1'b0, "R8", "no overflow under load", overflow, 0);
    end

    // Directed: back-pressure until the buffer overflows
    do_reset(32'h2000_0000, 16'hBEEF);
    repeat (400) step(1'b0, 1'b1, 32'h2000_0000, 1'b1);
    check(overflow == 1'b1, "R8", "overflow raised", overflow, 1);
    check(out_valid == 1'b1, "R7", "valid held while stalled", out_valid, 1);
    held_i = out_i;
    repeat (20) step(1'b0, 1'b0, 32'h2000_0000, 1'b0);
    check(out_valid == 1'b1 && out_i == held_i, "R7", "output held", out_i, held_i);
    repeat (60) step(1'b1, 1'b0, 32'h2000_0000, 1'b0);
    check(rx == DEPTH + 2, "R8", "words kept before drop", rx, DEPTH + 2);
    check(overflow == 1'b1, "R8", "overflow sticky", overflow, 1);

    report();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    report();
    $finish;
  end
endmodule